// File: doc/BRIEF.md
# Transmit Bit Encoder and Load Modulator

This block converts a serial stream of NRZ transmit bits into the single control line that switches a resistive load across a coil. It is built from two stages in series, and each stage can be bypassed. The first stage is an edge-inserting data encoder. It passes NRZ through unchanged, or it applies Manchester or Miller coding. An optional inverter can follow it. The second stage shapes that level for the air interface. It offers plain amplitude keying, a subcarrier at half the carrier rate gated by the encoded level, or one of two phase-shift-keyed variants of that subcarrier.

The block advances only on a one-clock enable that marks each carrier cycle. A start pulse does three things: it latches the rate, encoding, inversion and modulation settings, it takes the first data bit, and it begins streaming. After that, the block raises a request for the next bit during the last carrier cycle of every bit period. It samples that bit at the boundary, so consecutive bits follow one another with no gap. Streaming continues until reset or the next start pulse.

Top module: `txmod_top`

## Requirements
- R1: One bit lasts (rate_sel+1)*16 carrier cycles. bit_req is high for exactly the last carrier cycle of each bit. bit_in is sampled on the carrier enable that ends that cycle and becomes the next bit.
- R2: After reset, and until the first start pulse, load_on and bit_req stay 0 even while car_en pulses.
- R3: enc_sel values 2'b00 and 2'b11 select NRZ, where the encoder output equals the current bit for the whole bit.
- R4: enc_sel 2'b01 selects Manchester. The output is the inverse of the bit during the first half of the bit and the bit itself during the second half, so a 1 rises mid-bit and a 0 falls mid-bit.
- R5: enc_sel 2'b10 selects Miller. A 1 toggles the level at mid-bit. A 0 that follows a 0 toggles it at the bit start. A 0 that follows a 1 toggles nothing. The coder starts as if the previous bit were 0 and the level were 0, so a leading 0 gives a high level for the whole first bit.
- R6: When inv_en is 1, the encoder output is inverted before the modulation stage.
- R7: mod_sel 2'b00 selects amplitude keying: load_on equals the encoder output.
- R8: mod_sel 2'b11 selects subcarrier gating. load_on is the subcarrier AND the encoder output. The subcarrier starts at 0 at start and toggles on every carrier enable.
- R9: mod_sel 2'b01 selects PSK1, where load_on is the subcarrier. The toggle is skipped on the carrier enable that ends the first carrier cycle of a bit if the encoder output is 1 in that cycle.
- R10: mod_sel 2'b10 selects PSK2, where load_on is the subcarrier. A toggle is skipped on any carrier enable where the encoder output differs from its value in the previous carrier cycle. That value is taken as 0 at start.
- R11: While car_en is low, load_on and bit_req do not change.
- R12: rate_sel, enc_sel, inv_en and mod_sel are captured only at start. Changes to them during a stream have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| car_en | input | 1 | One-clock enable marking each carrier cycle |
| rate_sel | input | 6 | Bit length code: (value+1)*16 carrier cycles |
| enc_sel | input | 2 | Encoder mode: 00/11 NRZ, 01 Manchester, 10 Miller |
| inv_en | input | 1 | Invert the encoder output |
| mod_sel | input | 2 | Modulator mode: 00 ASK, 01 PSK1, 10 PSK2, 11 subcarrier |
| start | input | 1 | Latch settings and the first bit, begin streaming |
| bit_in | input | 1 | Next NRZ data bit |
| bit_req | output | 1 | High during the last carrier cycle of each bit |
| load_on | output | 1 | 1 applies the modulation load |

## Verification
The hardest states to reach are the Miller level after long runs of mixed zeros and ones and the accumulated phase of the PSK subcarrier. Both depend on the whole history since start, and neither is visible at a port as a single value. The bench streams bit patterns through every encoder and modulator pairing while running an independent cycle-level model of the coding rules, and compares load_on on every carrier cycle. One run stretches the carrier enable to every third clock. Another scrambles the settings right after start. Together these reach the enable-gap and latched-configuration corners without any visibility into internal state.

// File: rtl/txmod_pkg.sv
package txmod_pkg;
    parameter int RATE_W    = 6;
    parameter int UNIT_LOG2 = 4;
    localparam int CNT_W    = RATE_W + UNIT_LOG2;

    typedef enum logic [1:0] {
        ENC_NRZ_A = 2'b00,
        ENC_MAN   = 2'b01,
        ENC_MIL   = 2'b10,
        ENC_NRZ_B = 2'b11
    } enc_mode_e;

    typedef enum logic [1:0] {
        MOD_ASK  = 2'b00,
        MOD_PSK1 = 2'b01,
        MOD_PSK2 = 2'b10,
        MOD_SUB  = 2'b11
    } mod_mode_e;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        enc_mode_e         enc;
        logic              inv;
        mod_mode_e         modm;
    } txcfg_t;

    function automatic logic [CNT_W:0] bit_period(input logic [RATE_W-1:0] r);
        return ((CNT_W+1)'(r) + (CNT_W+1)'(1)) << UNIT_LOG2;
    endfunction
endpackage

// File: rtl/txmod_timer.sv
module txmod_timer
    import txmod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              car_en,
    input  logic              start,
    input  logic [RATE_W-1:0] rate,
    output logic              run,
    output logic              bound_evt,
    output logic              mid_evt,
    output logic              first_cyc,
    output logic              second_half,
    output logic              bit_req
);
    logic [CNT_W-1:0] cyc;
    logic [CNT_W:0]   period, last_c, half_c, cyc_x;
    logic             at_last;

    assign period  = bit_period(rate);
    assign last_c  = period - 1'b1;
    assign half_c  = period >> 1;
    assign cyc_x   = {1'b0, cyc};
    assign at_last = (cyc_x == last_c);

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            cyc <= '0;
        end else if (start) begin
            run <= 1'b1;
            cyc <= '0;
        end else if (run && car_en) begin
            cyc <= at_last ? '0 : cyc + 1'b1;
        end
    end

    assign bound_evt   = run && car_en && !start && at_last;
    assign mid_evt     = run && car_en && !start && (cyc_x == half_c - 1'b1);
    assign first_cyc   = (cyc == '0);
    assign second_half = (cyc_x >= half_c);
    assign bit_req     = run && at_last;
endmodule

// File: rtl/txmod_encoder.sv
module txmod_encoder
    import txmod_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      bit_in,
    input  logic      bound_evt,
    input  logic      mid_evt,
    input  logic      second_half,
    input  enc_mode_e mode,
    input  logic      inv,
    output logic      enc_out
);
    logic cur_bit;
    logic mil_lvl;
    logic raw;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_bit <= 1'b0;
            mil_lvl <= 1'b0;
        end else if (start) begin
            cur_bit <= bit_in;
            mil_lvl <= !bit_in;
        end else if (bound_evt) begin
            cur_bit <= bit_in;
            if (!bit_in && !cur_bit)
                mil_lvl <= !mil_lvl;
        end else if (mid_evt && cur_bit) begin
            mil_lvl <= !mil_lvl;
        end
    end

    always_comb begin
        unique case (mode)
            ENC_MAN: raw = second_half ? cur_bit : !cur_bit;
            ENC_MIL: raw = mil_lvl;
            default: raw = cur_bit;
        endcase
    end

    assign enc_out = raw ^ inv;
endmodule

// File: rtl/txmod_modulator.sv
module txmod_modulator
    import txmod_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      run,
    input  logic      car_en,
    input  logic      first_cyc,
    input  mod_mode_e mode,
    input  logic      enc_out,
    output logic      load_on
);
    logic sc;
    logic enc_q;
    logic skip;

    always_comb begin
        unique case (mode)
            MOD_PSK1: skip = first_cyc && enc_out;
            MOD_PSK2: skip = (enc_out != enc_q);
            default:  skip = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            sc    <= 1'b0;
            enc_q <= 1'b0;
        end else if (run && car_en) begin
            enc_q <= enc_out;
            if (!skip)
                sc <= !sc;
        end
    end

    always_comb begin
        unique case (mode)
            MOD_ASK: load_on = run && enc_out;
            MOD_SUB: load_on = run && enc_out && sc;
            default: load_on = run && sc;
        endcase
    end
endmodule

// File: rtl/txmod_top.sv
module txmod_top
    import txmod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              car_en,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic [1:0]        enc_sel,
    input  logic              inv_en,
    input  logic [1:0]        mod_sel,
    input  logic              start,
    input  logic              bit_in,
    output logic              bit_req,
    output logic              load_on
);
    txcfg_t    cfg_q;
    logic      run, bound_evt, mid_evt, first_cyc, second_half, enc_out;
    enc_mode_e enc_cur;
    mod_mode_e mod_cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (start) begin
            cfg_q.rate <= rate_sel;
            cfg_q.enc  <= enc_mode_e'(enc_sel);
            cfg_q.inv  <= inv_en;
            cfg_q.modm <= mod_mode_e'(mod_sel);
        end
    end

    assign enc_cur = cfg_q.enc;
    assign mod_cur = cfg_q.modm;

    txmod_timer i_timer (
        .clk(clk), .rst(rst), .car_en(car_en), .start(start), .rate(cfg_q.rate),
        .run(run), .bound_evt(bound_evt), .mid_evt(mid_evt), .first_cyc(first_cyc),
        .second_half(second_half), .bit_req(bit_req)
    );

    txmod_encoder i_enc (
        .clk(clk), .rst(rst), .start(start), .bit_in(bit_in), .bound_evt(bound_evt),
        .mid_evt(mid_evt), .second_half(second_half), .mode(enc_cur), .inv(cfg_q.inv),
        .enc_out(enc_out)
    );

    txmod_modulator i_mod (
        .clk(clk), .rst(rst), .start(start), .run(run), .car_en(car_en),
        .first_cyc(first_cyc), .mode(mod_cur), .enc_out(enc_out), .load_on(load_on)
    );
endmodule

// File: rtl/txmod_checks.sv
module txmod_checks (
    input logic       clk,
    input logic       rst,
    input logic       car_en,
    input logic       start,
    input logic       run,
    input logic       bit_req,
    input logic       load_on,
    input logic       enc_out,
    input logic       mid_evt,
    input logic [1:0] enc_sel_q,
    input logic [1:0] mod_sel_q
);
    p_req_single_r1: assert property (@(posedge clk) disable iff (rst)
        (bit_req && car_en && !start) |=> !bit_req);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !run |-> (!load_on && !bit_req));

    p_manch_mid_r4: assert property (@(posedge clk) disable iff (rst)
        (run && enc_sel_q == 2'b01 && mid_evt) |=> (enc_out != $past(enc_out)));

    p_ask_follow_r7: assert property (@(posedge clk) disable iff (rst)
        (run && mod_sel_q == 2'b00) |-> (load_on == enc_out));

    p_sub_gate_r8: assert property (@(posedge clk) disable iff (rst)
        (run && mod_sel_q == 2'b11 && !enc_out) |-> !load_on);

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (run && !car_en && !start) |=> ($stable(load_on) && $stable(bit_req)));
endmodule

bind txmod_top txmod_checks i_chk (
    .clk(clk), .rst(rst), .car_en(car_en), .start(start), .run(run),
    .bit_req(bit_req), .load_on(load_on), .enc_out(enc_out), .mid_evt(mid_evt),
    .enc_sel_q(enc_cur), .mod_sel_q(mod_cur)
);

// File: tb/test_txmod_top.sv
module test_txmod_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       car_en = 1'b0;
    logic [5:0] rate_sel = '0;
    logic [1:0] enc_sel = '0;
    logic       inv_en = 1'b0;
    logic [1:0] mod_sel = '0;
    logic       start = 1'b0;
    logic       bit_in = 1'b0;
    logic       bit_req, load_on;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txmod_top i_txmod_top (
        .clk(clk), .rst(rst), .car_en(car_en), .rate_sel(rate_sel), .enc_sel(enc_sel),
        .inv_en(inv_en), .mod_sel(mod_sel), .start(start), .bit_in(bit_in),
        .bit_req(bit_req), .load_on(load_on)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; car_en = 1'b0; start = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R2 load_on after reset", int'(load_on), 0);
        chk("R2 bit_req after reset", int'(bit_req), 0);
    endtask

    task automatic test_idle();
        do_reset();
        for (int n = 0; n < 20; n++) begin
            car_en = n[0];
            bit_in = n[1];
            @(negedge clk);
            chk("R2 idle load_on", int'(load_on), 0);
            chk("R2 idle bit_req", int'(bit_req), 0);
        end
        car_en = 1'b0;
    endtask

    // Streams nb bits (bits[0] first) and compares every carrier cycle
    task automatic run_stream(input string req, input logic [1:0] e_m, input logic iv,
                              input logic [1:0] m_m, input logic [5:0] rt,
                              input logic [31:0] bits, input int nb, input int div,
                              input bit scramble);
        int   per, half;
        logic lvl, sc, eq, e, b, prevb, expo, skip, expr;
        per  = (int'(rt) + 1) * 16;
        half = per / 2;
        do_reset();
        @(negedge clk);
        rate_sel = rt; enc_sel = e_m; inv_en = iv; mod_sel = m_m;
        bit_in = bits[0]; start = 1'b1; car_en = 1'b0;
        @(negedge clk);
        start = 1'b0;
        if (scramble) begin
            rate_sel = ~rt; enc_sel = ~e_m; inv_en = ~iv; mod_sel = ~m_m;
        end
        sc = 1'b0; eq = 1'b0; lvl = 1'b0; prevb = 1'b0;
        for (int i = 0; i < nb; i++) begin
            b = bits[i];
            for (int k = 0; k < per; k++) begin
                if (k == 0) begin
                    if (i == 0) lvl = !b;
                    else if (!b && !prevb) lvl = !lvl;
                end
                if (k == half && b) lvl = !lvl;
                case (e_m)
                    2'b01:   e = (k >= half) ? b : !b;
                    2'b10:   e = lvl;
                    default: e = b;
                endcase
                e = e ^ iv;
                case (m_m)
                    2'b00:   expo = e;
                    2'b11:   expo = e & sc;
                    default: expo = sc;
                endcase
                expr = (k == per - 1);
                chk({req, " load_on"}, int'(load_on), int'(expo));
                chk("R1 bit_req", int'(bit_req), int'(expr));
                if (k == per - 1) bit_in = (i + 1 < nb) ? bits[i+1] : 1'b0;
                skip = (m_m == 2'b01 && k == 0 && e) || (m_m == 2'b10 && e != eq);
                if (!skip) sc = !sc;
                eq = e;
                for (int d = 0; d < div; d++) begin
                    if (d != 0) begin
                        chk("R11 load_on held", int'(load_on), int'(expo));
                        chk("R11 bit_req held", int'(bit_req), int'(expr));
                    end
                    car_en = (d == div - 1);
                    @(negedge clk);
                end
                car_en = 1'b0;
            end
            prevb = b;
        end
    endtask

    task automatic test_nrz();
        run_stream("R3 R7 nrz00 ask", 2'b00, 1'b0, 2'b00, 6'd0, 32'h0000_004D, 8, 1, 1'b0);
        run_stream("R3 nrz11 ask", 2'b11, 1'b0, 2'b00, 6'd0, 32'h0000_00B2, 8, 1, 1'b0);
    endtask

    task automatic test_manchester();
        run_stream("R4 manchester", 2'b01, 1'b0, 2'b00, 6'd2, 32'h0000_0036, 6, 1, 1'b0);
    endtask

    task automatic test_miller();
        run_stream("R5 miller lead0", 2'b10, 1'b0, 2'b00, 6'd0, 32'h0000_0B2C, 12, 1, 1'b0);
        run_stream("R5 miller lead1", 2'b10, 1'b0, 2'b00, 6'd0, 32'h0000_0993, 12, 1, 1'b0);
    endtask

    task automatic test_invert();
        run_stream("R6 inv miller", 2'b10, 1'b1, 2'b00, 6'd0, 32'h0000_00C4, 8, 1, 1'b0);
        run_stream("R6 inv manchester", 2'b01, 1'b1, 2'b00, 6'd1, 32'h0000_0005, 4, 1, 1'b0);
    endtask

    task automatic test_sub();
        run_stream("R8 subcarrier", 2'b01, 1'b0, 2'b11, 6'd0, 32'h0000_00A6, 8, 1, 1'b0);
    endtask

    task automatic test_psk1();
        run_stream("R9 psk1", 2'b00, 1'b0, 2'b01, 6'd0, 32'h0000_00E5, 8, 1, 1'b0);
    endtask

    task automatic test_psk2();
        run_stream("R10 psk2 manchester", 2'b01, 1'b0, 2'b10, 6'd0, 32'h0000_0073, 8, 1, 1'b0);
        run_stream("R10 psk2 miller", 2'b10, 1'b0, 2'b10, 6'd0, 32'h0000_0058, 8, 1, 1'b0);
    endtask

    task automatic test_slow_enable();
        run_stream("R11 slow psk2", 2'b10, 1'b0, 2'b10, 6'd1, 32'h0000_0019, 6, 3, 1'b0);
    endtask

    task automatic test_latched();
        run_stream("R12 latched cfg", 2'b01, 1'b0, 2'b11, 6'd1, 32'h0000_002B, 6, 1, 1'b1);
    endtask

    task automatic test_long_bit();
        run_stream("R1 long bit", 2'b01, 1'b0, 2'b00, 6'd63, 32'h0000_0002, 2, 1, 1'b0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        test_idle();
        test_nrz();
        test_manchester();
        test_miller();
        test_invert();
        test_sub();
        test_psk1();
        test_psk2();
        test_slow_enable();
        test_latched();
        test_long_bit();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule